// File: doc/BRIEF.md
# Three-Lane LFSR Key and IV Loader

This block carries out the loading phase of a stream cipher whose state is held in three binary linear feedback shift registers of 19, 22 and 23 stages. A `start` request clears every stage to zero. The block then steps all three registers together, with no irregular clocking, for 86 cycles. On each cycle one input bit is XORed into the feedback bit of every register. The first 64 cycles take the 64 key bits and the last 22 cycles take the 22 IV bits.

The bits come either from the parallel `key` and `iv` words, least-significant bit first, or from a serial pin that is read once per loading cycle. When loading finishes the block raises `done` for one cycle and drops `busy`. It exposes the concatenated 64-bit loaded state and raises one flag for each register that ends up all zero, a condition known to be weak. The state then holds until the next accepted `start`. Irregular clocking and keystream output belong to a later stage.

Top module: `lfsr3_iv_loader`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `busy` and `done` are 0, `state` is all zeros, and all three zero flags are 1.
- R2: `start` sampled high while `busy` is 0 is accepted: at that edge all stages clear to zero and `busy` goes to 1.
- R3: On each loading cycle every register shifts towards its higher stage index, and stage 0 takes the XOR of the input bit with the register's taps. The taps are stages 13, 16, 17 and 18 for the 19-stage register, stages 20 and 21 for the 22-stage register, and stages 7, 20, 21 and 22 for the 23-stage register.
- R4: In parallel mode (`serial_en` 0 when the start is accepted), loading cycle k for k from 0 to 63 uses `key[k]`, and loading cycle 64+j for j from 0 to 21 uses `iv[j]`. The key and IV values are captured at acceptance.
- R5: In serial mode (`serial_en` 1 when the start is accepted), loading cycle k uses the value of `ser_din` at the clock edge that performs that cycle. That edge is the (k+1)-th edge after acceptance.
- R6: `done` is 1 for exactly one cycle, starting at the 86th clock edge after acceptance. `busy` is 0 from that same edge.
- R7: A `start` that arrives while `busy` is 1 is ignored. The loaded state, the done timing and the mode stay those of the load already in progress.
- R8: While `busy` is 0 and no start is accepted, `state` and the zero flags hold their values.
- R9: `state[18:0]` is the 19-stage register, `state[40:19]` the 22-stage register and `state[63:41]` the 23-stage register, with bit i of each field being stage i. `zero_a`, `zero_b` and `zero_c` are 1 exactly when the corresponding field is all zero.
- R10: A synchronous reset during loading abandons the load. The block returns to idle with cleared registers and does not raise `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a loading phase |
| serial_en | input | 1 | Selects serial input for the requested load |
| ser_din | input | 1 | Serial input bit, one per loading cycle |
| key | input | 64 | Parallel key, bit 0 used first |
| iv | input | 22 | Parallel IV, bit 0 used first |
| busy | output | 1 | Loading in progress |
| done | output | 1 | One-cycle strobe when loading completes |
| state | output | 64 | Concatenated loaded register state |
| zero_a | output | 1 | 19-stage register is all zero |
| zero_b | output | 1 | 22-stage register is all zero |
| zero_c | output | 1 | 23-stage register is all zero |

## Verification
The only timed result is the done strobe with its state and flags. It is due at the 86th edge after the accepted start, and `busy` falls on the same edge. The driver records the cycle count just after acceptance and queues the state its own bit-level model expects, and the monitor checks that `done` appears exactly 86 counted edges later. All inputs change and all outputs are sampled on the falling edge. In serial mode each input bit is set up half a cycle before the edge that consumes it. After a start sent during loading, after the hold window and after a mid-load reset, the bench reads the outputs on the falling edge that follows.

// File: rtl/lfsr_load_pkg.sv
package lfsr_load_pkg;
  localparam int unsigned NUM_LANES = 3;
  localparam int unsigned KEY_W     = 64;
  localparam int unsigned IV_W      = 22;
  localparam int unsigned FEED_W    = KEY_W + IV_W;
  localparam int unsigned CNT_W     = $clog2(FEED_W);

  localparam int unsigned LANE_LEN [NUM_LANES] = '{19, 22, 23};
  localparam logic [31:0] LANE_TAPS [NUM_LANES] = '{
    32'h0007_2000,   // stages 13,16,17,18
    32'h0030_0000,   // stages 20,21
    32'h0070_0080    // stages 7,20,21,22
  };

  localparam int unsigned STATE_W = LANE_LEN[0] + LANE_LEN[1] + LANE_LEN[2];

  // Bit offset of a lane inside the concatenated state
  function automatic int unsigned lane_offset(input int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned i = 0; i < NUM_LANES; i++)
      if (i < idx) acc += LANE_LEN[i];
    return acc;
  endfunction

  // Parity of the tapped stages
  function automatic logic tap_parity(input logic [31:0] stages, input logic [31:0] taps);
    return ^(stages & taps);
  endfunction
endpackage

// File: rtl/lfsr_lane.sv
module lfsr_lane #(
  parameter int unsigned LEN  = 19,
  parameter logic [31:0] TAPS = 32'h0007_2000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           step,
  input  logic           din,
  output logic [LEN-1:0] q,
  output logic           all_zero
);
  logic fb;

  assign fb       = lfsr_load_pkg::tap_parity(32'(q), TAPS) ^ din;
  assign all_zero = (q == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (step)  q <= {q[LEN-2:0], fb};
  end

  // R3: stages move up by one on each step
  a_r3_shift_up: assert property (@(posedge clk) disable iff (rst)
    (step && !clr) |=> q[LEN-1:1] == $past(q[LEN-2:0]));

  // R2: a clear empties the register
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0);
endmodule

// File: rtl/load_seq.sv
module load_seq #(
  parameter int unsigned STEPS = 86,
  localparam int unsigned CW   = $clog2(STEPS)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic step,
  output logic busy,
  output logic done
);
  logic [CW-1:0] cnt;
  logic          last_step;

  assign accept    = start && !busy;
  assign step      = busy;
  assign last_step = busy && (cnt == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: done lasts one cycle and coincides with idle
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R2: acceptance enters loading from count zero
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && cnt == '0));
  // R7: a start during loading does not restart the count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last_step) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/feed_source.sv
module feed_source #(
  parameter int unsigned KW = 64,
  parameter int unsigned VW = 22,
  localparam int unsigned FW = KW + VW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          accept,
  input  logic          step,
  input  logic          serial_en,
  input  logic          ser_din,
  input  logic [KW-1:0] key,
  input  logic [VW-1:0] iv,
  output logic          feed_bit
);
  logic [FW-1:0] sh;
  logic          ser_mode;

  assign feed_bit = ser_mode ? ser_din : sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      ser_mode <= 1'b0;
    end else if (accept) begin
      sh       <= {iv, key};
      ser_mode <= serial_en;
    end else if (step) begin
      sh <= {1'b0, sh[FW-1:1]};
    end
  end

  // R4: parallel bits are consumed lowest first
  a_r4_lsb_first: assert property (@(posedge clk) disable iff (rst)
    (step && !accept) |=> sh[FW-2:0] == $past(sh[FW-1:1]));
  // R5: mode only changes at acceptance
  a_r5_mode_kept: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(ser_mode));
endmodule

// File: rtl/lfsr3_iv_loader.sv
module lfsr3_iv_loader (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        serial_en,
  input  logic        ser_din,
  input  logic [63:0] key,
  input  logic [21:0] iv,
  output logic        busy,
  output logic        done,
  output logic [63:0] state,
  output logic        zero_a,
  output logic        zero_b,
  output logic        zero_c
);
  import lfsr_load_pkg::*;

  logic accept;
  logic step;
  logic feed_bit;
  logic [NUM_LANES-1:0] lane_zero;

  load_seq #(.STEPS(FEED_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .accept(accept), .step(step), .busy(busy), .done(done)
  );

  feed_source #(.KW(KEY_W), .VW(IV_W)) u_feed (
    .clk(clk), .rst(rst), .accept(accept), .step(step),
    .serial_en(serial_en), .ser_din(ser_din),
    .key(key), .iv(iv), .feed_bit(feed_bit)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int unsigned L   = LANE_LEN[g];
    localparam int unsigned OFF = lane_offset(g);
    logic [L-1:0] lane_q;

    lfsr_lane #(.LEN(L), .TAPS(LANE_TAPS[g])) u_lane (
      .clk(clk), .rst(rst), .clr(accept), .step(step),
      .din(feed_bit), .q(lane_q), .all_zero(lane_zero[g])
    );

    assign state[OFF +: L] = lane_q;
  end

  assign zero_a = lane_zero[0];
  assign zero_b = lane_zero[1];
  assign zero_c = lane_zero[2];

  // R8: idle without a new request keeps the loaded state
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(state));
  // R9: a flag never reports zero for a register that holds a one
  a_r9_flag_a: assert property (@(posedge clk) disable iff (rst)
    zero_a |-> $countones(state[18:0]) == 0);
endmodule

// File: tb/tb_lfsr3_iv_loader.sv
module tb_lfsr3_iv_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        serial_en = 1'b0;
  logic        ser_din = 1'b0;
  logic [63:0] key = '0;
  logic [21:0] iv = '0;
  logic        busy, done, zero_a, zero_b, zero_c;
  logic [63:0] state;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct { logic [63:0] st; logic [2:0] z; int t0; string tag; } exp_t;
  exp_t sbq[$];

  lfsr3_iv_loader dut (
    .clk(clk), .rst(rst), .start(start), .serial_en(serial_en), .ser_din(ser_din),
    .key(key), .iv(iv), .busy(busy), .done(done), .state(state),
    .zero_a(zero_a), .zero_b(zero_b), .zero_c(zero_c)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // Reference model: feed[k] is the bit XORed in on loading cycle k
  function automatic logic [63:0] model(input logic [85:0] feed);
    logic [18:0] a; logic [21:0] b; logic [22:0] c;
    logic fa, fb, fc;
    a = '0; b = '0; c = '0;
    for (int k = 0; k < 86; k++) begin
      fa = a[13] ^ a[16] ^ a[17] ^ a[18] ^ feed[k];
      fb = b[20] ^ b[21] ^ feed[k];
      fc = c[7] ^ c[20] ^ c[21] ^ c[22] ^ feed[k];
      for (int i = 18; i > 0; i--) a[i] = a[i-1];
      for (int i = 21; i > 0; i--) b[i] = b[i-1];
      for (int i = 22; i > 0; i--) c[i] = c[i-1];
      a[0] = fa; b[0] = fb; c[0] = fc;
    end
    return {c, b, a};
  endfunction

  function automatic exp_t make_exp(input logic [85:0] feed, input string tag);
    exp_t e;
    e.st   = model(feed);
    e.z[0] = (e.st[18:0] == '0);
    e.z[1] = (e.st[40:19] == '0);
    e.z[2] = (e.st[63:41] == '0);
    e.t0   = 0;
    e.tag  = tag;
    return e;
  endfunction

  // Monitor: pop and compare on each done strobe
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R6", "unexpected done", 64'd1, 64'd0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(state == e.st, "R3/R4/R5", {e.tag, " state"}, state, e.st);
        chk({zero_c, zero_b, zero_a} == e.z, "R9", {e.tag, " zero flags"},
            64'({zero_c, zero_b, zero_a}), 64'(e.z));
        chk(cyc == e.t0 + 86, "R6", {e.tag, " done timing"}, 64'(cyc), 64'(e.t0 + 86));
        chk(!busy, "R6", {e.tag, " busy low at done"}, 64'(busy), 64'd0);
      end
    end
    if (!rst && prev_done && done)
      chk(1'b0, "R6", "done longer than one cycle", 64'd1, 64'd0);
    prev_done <= done;
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic run_par(input logic [63:0] k, input logic [21:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    key = k; iv = v; serial_en = 1'b0; start = 1'b1;
    e = make_exp({v, k}, tag);
    @(negedge clk);
    start = 1'b0;
    e.t0 = cyc;
    sbq.push_back(e);
  endtask

  task automatic run_ser(input logic [85:0] feed, input string tag);
    exp_t e;
    @(negedge clk);
    serial_en = 1'b1; start = 1'b1;
    key = ~key; iv = ~iv;
    e = make_exp(feed, tag);
    for (int k = 0; k < 86; k++) begin
      @(negedge clk);
      if (k == 0) begin
        start = 1'b0; serial_en = 1'b0;
        e.t0 = cyc;
        sbq.push_back(e);
      end
      ser_din = feed[k];
    end
  endtask

  // Serial stream that drives the 19-stage register to zero over its last 19 cycles
  function automatic logic [85:0] zero_a_stream();
    logic [85:0] f; logic [18:0] a; logic fa; logic [31:0] lf;
    a = '0; lf = 32'hACE1_2345;
    for (int k = 0; k < 86; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (k < 67) f[k] = lf[0];
      else        f[k] = a[13] ^ a[16] ^ a[17] ^ a[18];
      fa = a[13] ^ a[16] ^ a[17] ^ a[18] ^ f[k];
      for (int i = 18; i > 0; i--) a[i] = a[i-1];
      a[0] = fa;
    end
    return f;
  endfunction

  initial begin
    logic [63:0] held;
    logic [85:0] zs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(!busy && !done, "R1", "busy/done after reset", 64'({busy, done}), 64'd0);
    chk(state == '0, "R1", "state after reset", state, 64'd0);
    chk({zero_c, zero_b, zero_a} == 3'b111, "R1", "zero flags after reset",
        64'({zero_c, zero_b, zero_a}), 64'd7);

    run_par(64'h0123_4567_89AB_CDEF, 22'h2A_5A5A, "R4 pattern1");
    chk(busy, "R2", "busy after accept", 64'(busy), 64'd1);
    wait_done();
    run_par(64'h8000_0000_0000_0001, 22'h20_0001, "R4 end bits");
    wait_done();
    run_par(64'hFFFF_FFFF_FFFF_FFFF, 22'h3F_FFFF, "R4 all ones");
    wait_done();
    run_par(64'h0, 22'h0, "R9 all zero key");
    wait_done();
    chk(zero_a && zero_b && zero_c, "R9", "zero key gives zero flags", 64'({zero_c, zero_b, zero_a}), 64'd7);

    // R8: hold after done
    run_par(64'hDEAD_BEEF_0BAD_F00D, 22'h15_3C3C, "R8 hold case");
    wait_done();
    held = state;
    repeat (20) @(negedge clk);
    chk(state == held && !busy, "R8", "state held while idle", state, held);

    // R7: start during loading ignored
    run_par(64'h1357_9BDF_2468_ACE0, 22'h0F_0F0F, "R7 original load");
    repeat (10) @(negedge clk);
    key = 64'hFFFF_0000_FFFF_0000; iv = 22'h3F_0000; serial_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; serial_en = 1'b0;
    chk(busy, "R7", "still busy after ignored start", 64'(busy), 64'd1);
    wait_done();
    repeat (100) @(negedge clk);
    chk(sbq.size() == 0 && !busy, "R7", "no second load", 64'(sbq.size()), 64'd0);

    // R5: serial mode
    run_ser(86'h2A_BCDE_F012_3456_789A_BCDE, "R5 serial");
    wait_done();
    zs = zero_a_stream();
    run_ser(zs, "R9 serial zero A");
    wait_done();
    chk(zero_a, "R9", "19-stage register flagged zero", 64'(zero_a), 64'd1);
    chk(state[18:0] == '0, "R9", "19-stage field zero", 64'(state[18:0]), 64'd0);

    // R10: reset during loading
    run_par(64'hCAFE_CAFE_CAFE_CAFE, 22'h12_3456, "R10 aborted");
    repeat (30) @(negedge clk);
    rst = 1'b1;
    sbq.delete();
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && state == '0, "R10", "idle and cleared after reset", state, 64'd0);
    repeat (100) @(negedge clk);
    chk(!busy && state == '0, "R10", "no completion after reset", state, 64'd0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule